// File: doc/BRIEF.md
# Dual-Lane ADC Capture Buffer

This block takes the output of a fast converter that has been split into two 10-bit lanes at half the conversion rate. One lane carries the even-numbered samples; the other carries the odd-numbered samples and trails it by half a clock period. Both lanes are retimed onto one capture clock. Each matching even/odd pair is then written in the same cycle into two separate stores, one for each lane. The samples pass through with no arithmetic of any kind.

A host controls the block with one run line. While the line is low, both stores are held empty. When the line goes high, capture begins at one word per clock and continues until the stores are full. Captured words are never overwritten. The host reads the data back through a registered parallel port. A select line chooses the store, and each strobe returns one word. Each word holds the 10-bit code left-justified in 16 bits, so the host divides by 64 to recover the code. Because of the retiming pipeline, the first two words of each store are filler and the host discards them.

Top module: `dual_lane_capture`

## Requirements
- R1: An even-lane sample present at the k-th rising edge after the run line goes high (k counted from 0) is stored unchanged at word index k+2 of the even store.
- R2: The odd lane is sampled on the falling clock edge that follows the even sample it partners. That odd sample is stored unchanged at the same word index k+2 of the odd store, written in the same cycle as its even partner.
- R3: While `cap_run` is low, both stores are empty, both full flags are 0 and `rd_data` is 0, with no clock needed. On every rising edge with `cap_run` high, one word is written to each store that is not yet full.
- R4: Word indices 0 and 1 of both stores read back as zero.
- R5: `rd_data` carries the stored 10-bit code in bits 15:6. Bits 5:0 are zero.
- R6: `rd_sel` = 0 selects the even store and `rd_sel` = 1 selects the odd store, both for reads and for `rd_empty`. `rd_empty` is 1 when every word written to the selected store has already been read.
- R7: After DEPTH words have been written, `even_full` and `odd_full` are 1. Further writes are dropped, and the stored words stay as they were.
- R8: A rising edge with `rd_stb` high and the selected store not empty loads the next unread word of that store into `rd_data`, visible after that edge, and advances that store's read position by one.
- R9: A strobe while the selected store is empty leaves `rd_data` unchanged and does not move the read position.
- R10: Changing `rd_sel` or strobing reads during capture does not alter writing into either store or the read position of the store that is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock; the even lane is sampled on the rising edge, the odd lane on the falling edge |
| cap_run | input | 1 | Low: asynchronous clear of both stores; high: capture runs |
| even_lane | input | 10 | Even-sample lane, stable around each rising edge |
| odd_lane | input | 10 | Odd-sample lane, half a period later, stable around each falling edge |
| rd_sel | input | 1 | Store select for reading: 0 even, 1 odd |
| rd_stb | input | 1 | Read strobe, one word per clock |
| rd_data | output | 16 | Last word read, code in bits 15:6 |
| rd_empty | output | 1 | Selected store has no unread words |
| even_full | output | 1 | Even store holds DEPTH words |
| odd_full | output | 1 | Odd store holds DEPTH words |

## Verification
The latency properties assume each lane holds its value over a full clock period that is centred on the edge that samples it. For the even lane this is the rising edge; for the odd lane it is the falling edge. The odd-lane property depends on this, because it compares the stored word with the lane value seen at the previous rising edge. The bench keeps to this assumption: it changes the even lane only at falling edges and the odd lane only just after rising edges. It also holds the odd lane at zero while capture is stopped, and it raises and lowers `cap_run` only at falling edges. As a result, the asynchronous clear never coincides with the odd-lane sampling edge.

// File: rtl/dual_lane_capture.sv
module dual_lane_capture #(
  parameter int DEPTH = 16,
  parameter int SW    = 10,
  parameter int RW    = 16
) (
  input  logic          clk,
  input  logic          cap_run,
  input  logic [SW-1:0] even_lane,
  input  logic [SW-1:0] odd_lane,
  input  logic          rd_sel,
  input  logic          rd_stb,
  output logic [RW-1:0] rd_data,
  output logic          rd_empty,
  output logic          even_full,
  output logic          odd_full
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int PAD = RW - SW;

  logic [SW-1:0] ev_s1, ev_s2, od_n, od_s1;
  logic [SW-1:0] lane_w [2];
  logic [SW-1:0] rword  [2];
  logic [CW-1:0] wcnt_v [2];
  logic [1:0]    full_v, empty_v;
  logic [SW-1:0] rd_q;

  always_ff @(negedge clk or negedge cap_run)
    if (!cap_run) od_n <= '0;
    else          od_n <= odd_lane;

  always_ff @(posedge clk or negedge cap_run)
    if (!cap_run) begin
      ev_s1 <= '0;
      ev_s2 <= '0;
      od_s1 <= '0;
    end else begin
      ev_s1 <= even_lane;
      ev_s2 <= ev_s1;
      od_s1 <= od_n;
    end

  assign lane_w[0] = ev_s2;
  assign lane_w[1] = od_s1;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    logic [SW-1:0] mem [DEPTH];
    logic [CW-1:0] wcnt, rcnt;
    logic          take;

    assign full_v[b]  = (wcnt == CW'(DEPTH));
    assign empty_v[b] = (rcnt == wcnt);
    assign take       = rd_stb && (rd_sel == 1'(b)) && !empty_v[b];
    assign rword[b]   = mem[rcnt[AW-1:0]];
    assign wcnt_v[b]  = wcnt;

    always_ff @(posedge clk or negedge cap_run)
      if (!cap_run)        wcnt <= '0;
      else if (!full_v[b]) wcnt <= wcnt + 1'b1;

    always_ff @(posedge clk or negedge cap_run)
      if (!cap_run)  rcnt <= '0;
      else if (take) rcnt <= rcnt + 1'b1;

    always_ff @(posedge clk)
      if (cap_run && !full_v[b]) mem[wcnt[AW-1:0]] <= lane_w[b];
  end

  always_ff @(posedge clk or negedge cap_run)
    if (!cap_run)                     rd_q <= '0;
    else if (rd_stb && !empty_v[rd_sel]) rd_q <= rword[rd_sel];

  assign rd_data   = {rd_q, {PAD{1'b0}}};
  assign rd_empty  = empty_v[rd_sel];
  assign even_full = full_v[0];
  assign odd_full  = full_v[1];
endmodule

module dlc_checker #(
  parameter int SW    = 10,
  parameter int RW    = 16,
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          cap_run,
  input logic [SW-1:0] even_lane,
  input logic [SW-1:0] odd_lane,
  input logic          rd_stb,
  input logic [RW-1:0] rd_data,
  input logic          rd_empty,
  input logic          even_full,
  input logic          odd_full,
  input logic [CW-1:0] wr_even,
  input logic [CW-1:0] wr_odd,
  input logic [SW-1:0] ev_wdata,
  input logic [SW-1:0] od_wdata
);
  logic [2:0] cyc;
  always_ff @(posedge clk or negedge cap_run)
    if (!cap_run)      cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 1'b1;

  a_r1_even_latency: assert property (@(posedge clk) disable iff (!cap_run)
    (cyc >= 3'd3) |-> ev_wdata == $past(even_lane, 2));
  a_r2_odd_latency: assert property (@(posedge clk) disable iff (!cap_run)
    (cyc >= 3'd3) |-> od_wdata == $past(odd_lane, 1));
  a_r7_hold_full: assert property (@(posedge clk) disable iff (!cap_run)
    even_full |=> $stable(wr_even) && even_full);
  a_r7_pair_full: assert property (@(posedge clk) disable iff (!cap_run)
    even_full == odd_full);
  a_r10_write_steady: assert property (@(posedge clk) disable iff (!cap_run)
    (!odd_full && cyc >= 3'd1) |=> wr_odd == CW'($past(wr_odd) + 1'b1));
  a_r9_empty_hold: assert property (@(posedge clk) disable iff (!cap_run)
    (rd_stb && rd_empty && cyc >= 3'd1) |=> $stable(rd_data));

  always @(posedge clk)
    if (cap_run === 1'b0)
      a_r3_idle_clear: assert (rd_empty && !even_full && !odd_full && rd_data == '0);
endmodule

bind dual_lane_capture dlc_checker #(.SW(SW), .RW(RW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .cap_run(cap_run), .even_lane(even_lane), .odd_lane(odd_lane),
  .rd_stb(rd_stb), .rd_data(rd_data), .rd_empty(rd_empty),
  .even_full(even_full), .odd_full(odd_full),
  .wr_even(wcnt_v[0]), .wr_odd(wcnt_v[1]), .ev_wdata(ev_s2), .od_wdata(od_s1)
);

// File: tb/tb_dual_lane_capture.sv
module tb_dual_lane_capture;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic cap_run = 1'b0;
  logic [9:0] even_lane = '0, odd_lane = '0;
  logic rd_sel = 1'b0, rd_stb = 1'b0;
  logic [15:0] rd_data;
  logic rd_empty, even_full, odd_full;

  int checks = 0, fails = 0;
  int seed = 1;
  int w = 0, run = 0;
  int r [2] = '{0, 0};
  logic [9:0] last = '0;
  string phase = "R3 idle";

  always #5 clk = ~clk;

  dual_lane_capture #(.DEPTH(DEPTH)) dut (
    .clk(clk), .cap_run(cap_run), .even_lane(even_lane), .odd_lane(odd_lane),
    .rd_sel(rd_sel), .rd_stb(rd_stb), .rd_data(rd_data), .rd_empty(rd_empty),
    .even_full(even_full), .odd_full(odd_full)
  );

  function automatic logic [9:0] src(int b, int s, int j);
    return b ? 10'((j * 53 + s * 7 + 600) & 1023) : 10'((j * 37 + s * 101 + 5) & 1023);
  endfunction

  function automatic logic [9:0] word(int b, int n);
    return (n < 2) ? 10'd0 : src(b, seed, n - 2);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual %0h expected %0h at %0t", req, phase, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!cap_run) begin
      w = 0; r[0] = 0; r[1] = 0; last = '0; run = 0;
    end else begin
      if (rd_stb && r[rd_sel] < w) begin
        last = word(rd_sel, r[rd_sel]);
        r[rd_sel]++;
      end
      if (w < DEPTH) w++;
      run++;
    end
    #1 odd_lane = cap_run ? src(1, seed, run - 1) : 10'd0;
    @(negedge clk);
    check("R5 R8 rd_data", rd_data, {last, 6'd0});
    check("R6 R9 rd_empty", rd_empty, r[rd_sel] == w);
    check("R7 even_full", even_full, w == DEPTH);
    check("R7 odd_full", odd_full, w == DEPTH);
    even_lane = src(0, seed, run);
  endtask

  task automatic cycles(int n, logic stb, logic sel);
    rd_stb = stb; rd_sel = sel;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    @(negedge clk);
    phase = "R3 idle";
    check("R3 reset rd_data", rd_data, 0);
    cycles(3, 1'b1, 1'b0);
    phase = "R1 R2 R3 capture";
    even_lane = src(0, seed, 0);
    cap_run = 1'b1;
    cycles(4, 1'b0, 1'b0);
    phase = "R4 R1 even readout";
    cycles(6, 1'b1, 1'b0);
    phase = "R4 R2 odd readout";
    cycles(3, 1'b1, 1'b1);
    phase = "R10 select toggling";
    for (int i = 0; i < 6; i++) cycles(1, 1'b1, 1'(i & 1));
    phase = "R7 fill";
    cycles(10, 1'b0, 1'b1);
    phase = "R9 R7 drain even";
    cycles(20, 1'b1, 1'b0);
    phase = "R9 R7 drain odd";
    cycles(20, 1'b1, 1'b1);
    phase = "R3 clear";
    cap_run = 1'b0;
    #1 check("R3 async clear rd_empty", rd_empty, 1);
    check("R3 async clear rd_data", rd_data, 0);
    cycles(2, 1'b0, 1'b0);
    seed = 2;
    even_lane = src(0, seed, 0);
    phase = "R9 R6 chase writer";
    cap_run = 1'b1;
    cycles(5, 1'b1, 1'b1);
    phase = "R8 R10 mixed reads";
    for (int i = 0; i < 30; i++) cycles(1, 1'(i % 3 != 0), 1'((i / 4) & 1));
    cycles(20, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog R3: actual still running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule